// File: doc/BRIEF.md
# Watchdog and Clock-Loss Reset Generator

This block produces a system reset from either of two supervisors. The first is a service watchdog. It runs on the system clock and counts through a fixed power-of-two prescaler, then a selectable post-divider, then a small timer. If software does not perform the two-write service sequence before that timer wraps past its top value, the watchdog fires. The second supervisor is a clock-loss monitor. It watches the system clock from an independent reference clock. When no system-clock activity arrives for a parameterised number of reference cycles, it fires once for that outage.

Both detectors feed one pulse generator in the reference-clock domain. That generator still works after the system clock has died. It drives a fixed-length reset pulse and keeps a two-bit cause code. The cause code stays set until it is cleared by a read strobe, and a clock loss outranks a watchdog expiry. Watchdog events cross into the reference domain as toggles through a synchroniser. System-clock activity reaches the monitor the same way, as a divide-by-two toggle.

Top module: `wdcm_reset_unit`

## Requirements
- R1: After both resets, `rst_pulse` is 0 and `cause_code` is 2'b00.
- R2: While `cop_en` is 0, the watchdog never produces a reset, however long it runs without service.
- R3: With `cop_en` set, the watchdog fires after 2^PRE_W × D × 2^TMR_W system cycles from the last clear or enable, when its timer rolls over past its maximum. The rising edge of `rst_pulse` follows within a few reference cycles of synchroniser delay.
- R4: `cop_rate` sets the post-divider D: code 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 4, and 2'b11 also gives 4.
- R5: A service write of 8'h55 followed directly by a service write of 8'hAA clears the watchdog. Any other value, any other order, or any other write between the two leaves it counting.
- R6: With `clkmon_en` set, a reset fires CM_TIMEOUT reference cycles after system-clock activity stops, plus synchroniser delay. It fires only once per outage. With `clkmon_en` clear, a stopped system clock causes no reset.
- R7: Every reset is a pulse of exactly PULSE_LEN reference cycles (16 by default).
- R8: `cause_code` reads 2'b01 for a watchdog reset and 2'b10 for a clock-loss reset. It is nonzero when a pulse begins. A clock loss replaces a held 2'b01, including when both fire in the same cycle. A watchdog event never replaces a held 2'b10.
- R9: A `cause_rd` strobe returns `cause_code` to 2'b00 on the next reference edge, unless a detector fires in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock: drives the watchdog and is the clock being monitored |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| ref_clk | input | 1 | Independent reference clock |
| ref_rst | input | 1 | Synchronous active-high reset, reference domain |
| cop_en | input | 1 | Watchdog enable (system domain) |
| cop_rate | input | 2 | Watchdog post-divider select |
| svc_we | input | 1 | Service write strobe (system domain) |
| svc_data | input | 8 | Service write value |
| clkmon_en | input | 1 | Clock-loss monitor enable (reference domain) |
| cause_rd | input | 1 | Cause read/clear strobe (reference domain) |
| rst_pulse | output | 1 | Reset pulse (reference domain) |
| cause_code | output | 2 | Held cause of the last reset |

## Verification
The assertions rely on a few conditions at the inputs. `cause_rd` and `clkmon_en` must change only in step with the reference clock. The reference clock must run freely, without gaps, while the system clock may stop. The stimulus meets these conditions in three ways. It drives reference-domain inputs on reference falling edges. It drives service writes and enables only on system falling edges while that clock runs. It chooses a reference period (14 ns) that is not a multiple of the system period (10 ns), so the synchronised activity toggle never looks frozen while the system clock runs. It also spaces trials so that each reset pulse and cause read completes before the next detector can fire.

// File: rtl/wdcm_pkg.sv
package wdcm_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_COP  = 2'b01,
        CAUSE_CLK  = 2'b10
    } cause_e;

    typedef enum logic {
        SVC_IDLE  = 1'b0,
        SVC_ARMED = 1'b1
    } svc_state_e;

    typedef struct packed {
        logic       clear;
        svc_state_e nxt;
    } svc_res_t;

    localparam logic [7:0] SVC_KEY_FIRST  = 8'h55;
    localparam logic [7:0] SVC_KEY_SECOND = 8'hAA;

    // Terminal count of the post-divider for a rate code.
    function automatic logic [1:0] rate_last(input logic [1:0] code);
        case (code)
            2'b00:   rate_last = 2'd0;
            2'b01:   rate_last = 2'd1;
            default: rate_last = 2'd3;
        endcase
    endfunction

    // Service sequence step for one write.
    function automatic svc_res_t svc_step(input svc_state_e cur, input logic [7:0] data);
        svc_res_t r;
        r.clear = (cur == SVC_ARMED) && (data == SVC_KEY_SECOND);
        r.nxt   = (data == SVC_KEY_FIRST) ? SVC_ARMED : SVC_IDLE;
        return r;
    endfunction

    // Cause merge: clock loss outranks watchdog.
    function automatic cause_e cause_merge(input cause_e cur, input logic ev_cop, input logic ev_clk);
        if (ev_clk)
            cause_merge = CAUSE_CLK;
        else if (ev_cop && (cur != CAUSE_CLK))
            cause_merge = CAUSE_COP;
        else
            cause_merge = cur;
    endfunction

endpackage

// File: rtl/wdcm_sync.sv
module wdcm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic chg
);
    localparam int LAST = STAGES - 1;

    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)
            sh_q <= '0;
        else
            sh_q <= {sh_q[STAGES-1:0], d};
    end

    // Any level change after the synchroniser marks one event.
    assign chg = sh_q[LAST] ^ sh_q[STAGES];

endmodule

// File: rtl/wdcm_cop.sv
module wdcm_cop
    import wdcm_pkg::*;
#(
    parameter int PRE_W = 15,
    parameter int TMR_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] rate,
    input  logic       svc_we,
    input  logic [7:0] svc_data,
    output logic       fire_tog
);
    svc_state_e       svc_q;
    svc_res_t         svc_r;
    logic [PRE_W-1:0] pre_q;
    logic [1:0]       post_q;
    logic [TMR_W-1:0] tmr_q;
    logic             svc_clear;
    logic             pre_wrap;
    logic             post_wrap;
    logic             tmr_wrap;
    logic [1:0]       post_last;

    always_comb begin
        svc_r     = svc_step(svc_q, svc_data);
        svc_clear = svc_we && svc_r.clear;
        post_last = rate_last(rate);
        pre_wrap  = &pre_q;
        post_wrap = pre_wrap && (post_q >= post_last);
        tmr_wrap  = post_wrap && (&tmr_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            svc_q    <= SVC_IDLE;
            pre_q    <= '0;
            post_q   <= '0;
            tmr_q    <= '0;
            fire_tog <= 1'b0;
        end else begin
            if (svc_we)
                svc_q <= svc_r.nxt;
            if (!en || svc_clear) begin
                pre_q  <= '0;
                post_q <= '0;
                tmr_q  <= '0;
            end else begin
                pre_q <= pre_q + 1'b1;
                if (pre_wrap)
                    post_q <= post_wrap ? 2'd0 : post_q + 2'd1;
                if (post_wrap)
                    tmr_q <= tmr_q + 1'b1;
                if (tmr_wrap)
                    fire_tog <= ~fire_tog;
            end
        end
    end

endmodule

// File: rtl/wdcm_clkmon.sv
module wdcm_clkmon #(
    parameter int TIMEOUT = 64,
    parameter int SYNC    = 2
) (
    input  logic mon_clk,
    input  logic mon_rst,
    input  logic ref_clk,
    input  logic ref_rst,
    input  logic en,
    output logic loss
);
    localparam int            CW       = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT - 1);

    logic          act_tog;
    logic          act_chg;
    logic [CW-1:0] cnt_q;
    logic          lost_q;

    // Activity toggle in the monitored domain.
    always_ff @(posedge mon_clk) begin
        if (mon_rst)
            act_tog <= 1'b0;
        else
            act_tog <= ~act_tog;
    end

    wdcm_sync #(.STAGES(SYNC)) u_act_sync (
        .clk (ref_clk),
        .rst (ref_rst),
        .d   (act_tog),
        .chg (act_chg)
    );

    assign loss = en && !act_chg && !lost_q && (cnt_q == CNT_LAST);

    always_ff @(posedge ref_clk) begin
        if (ref_rst || !en || act_chg) begin
            cnt_q  <= '0;
            lost_q <= 1'b0;
        end else if (loss) begin
            cnt_q  <= '0;
            lost_q <= 1'b1;
        end else if (!lost_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdcm_rstgen.sv
module wdcm_rstgen
    import wdcm_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   ev_cop,
    input  logic   ev_clk,
    input  logic   rd,
    output logic   pulse,
    output cause_e cause
);
    localparam int            CW       = $clog2(PULSE_LEN + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(PULSE_LEN);

    logic [CW-1:0] cnt_q;
    cause_e        cause_q;
    cause_e        cause_base;
    logic          ev_any;

    always_comb begin
        ev_any     = ev_cop || ev_clk;
        cause_base = rd ? CAUSE_NONE : cause_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            cause_q <= CAUSE_NONE;
        end else begin
            if (ev_any)
                cnt_q <= CNT_LOAD;
            else if (cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
            if (ev_any)
                cause_q <= cause_merge(cause_base, ev_cop, ev_clk);
            else if (rd)
                cause_q <= CAUSE_NONE;
        end
    end

    assign pulse = (cnt_q != '0);
    assign cause = cause_q;

endmodule

// File: rtl/wdcm_reset_unit.sv
module wdcm_reset_unit
    import wdcm_pkg::*;
#(
    parameter int PRE_W      = 15,
    parameter int TMR_W      = 8,
    parameter int CM_TIMEOUT = 64,
    parameter int SYNC       = 2,
    parameter int PULSE_LEN  = 16
) (
    input  logic       sys_clk,
    input  logic       sys_rst,
    input  logic       ref_clk,
    input  logic       ref_rst,
    input  logic       cop_en,
    input  logic [1:0] cop_rate,
    input  logic       svc_we,
    input  logic [7:0] svc_data,
    input  logic       clkmon_en,
    input  logic       cause_rd,
    output logic       rst_pulse,
    output logic [1:0] cause_code
);
    logic   cop_tog;
    logic   ev_cop;
    logic   ev_clk;
    cause_e cause_w;

    wdcm_cop #(.PRE_W(PRE_W), .TMR_W(TMR_W)) u_cop (
        .clk      (sys_clk),
        .rst      (sys_rst),
        .en       (cop_en),
        .rate     (cop_rate),
        .svc_we   (svc_we),
        .svc_data (svc_data),
        .fire_tog (cop_tog)
    );

    wdcm_sync #(.STAGES(SYNC)) u_cop_sync (
        .clk (ref_clk),
        .rst (ref_rst),
        .d   (cop_tog),
        .chg (ev_cop)
    );

    wdcm_clkmon #(.TIMEOUT(CM_TIMEOUT), .SYNC(SYNC)) u_clkmon (
        .mon_clk (sys_clk),
        .mon_rst (sys_rst),
        .ref_clk (ref_clk),
        .ref_rst (ref_rst),
        .en      (clkmon_en),
        .loss    (ev_clk)
    );

    wdcm_rstgen #(.PULSE_LEN(PULSE_LEN)) u_rstgen (
        .clk    (ref_clk),
        .rst    (ref_rst),
        .ev_cop (ev_cop),
        .ev_clk (ev_clk),
        .rd     (cause_rd),
        .pulse  (rst_pulse),
        .cause  (cause_w)
    );

    assign cause_code = cause_w;

endmodule

// File: rtl/wdcm_reset_unit_chk.sv
module wdcm_reset_unit_chk
    import wdcm_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input logic       ref_clk,
    input logic       ref_rst,
    input logic       cause_rd,
    input logic       rst_pulse,
    input logic [1:0] cause_code,
    input logic       ev_cop,
    input logic       ev_clk
);
    localparam int            RW      = $clog2(PULSE_LEN + 2);
    localparam logic [RW-1:0] RUN_MAX = RW'(PULSE_LEN + 1);

    logic [RW-1:0] run_q;

    always_ff @(posedge ref_clk) begin
        if (ref_rst || ev_cop || ev_clk)
            run_q <= '0;
        else if (rst_pulse && run_q != RUN_MAX)
            run_q <= run_q + 1'b1;
        else if (!rst_pulse)
            run_q <= '0;
    end

    // R7
    pulse_cap_chk: assert property (@(posedge ref_clk) disable iff (ref_rst)
        rst_pulse |-> (run_q < RW'(PULSE_LEN)));

    // R7
    pulse_width_chk: assert property (@(posedge ref_clk) disable iff (ref_rst)
        $fell(rst_pulse) |-> (run_q == RW'(PULSE_LEN)));

    // R8
    rise_cause_chk: assert property (@(posedge ref_clk) disable iff (ref_rst)
        $rose(rst_pulse) |-> (cause_code != 2'b00));

    // R8
    clk_prio_chk: assert property (@(posedge ref_clk) disable iff (ref_rst)
        ev_clk |=> (cause_code == 2'b10));

    // R8
    cop_cause_chk: assert property (@(posedge ref_clk) disable iff (ref_rst)
        (ev_cop && !ev_clk) |=> (cause_code != 2'b00));

    // R9
    read_clear_chk: assert property (@(posedge ref_clk) disable iff (ref_rst)
        (cause_rd && !ev_cop && !ev_clk) |=> (cause_code == 2'b00));

endmodule

bind wdcm_reset_unit wdcm_reset_unit_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .ref_clk    (ref_clk),
    .ref_rst    (ref_rst),
    .cause_rd   (cause_rd),
    .rst_pulse  (rst_pulse),
    .cause_code (cause_code),
    .ev_cop     (ev_cop),
    .ev_clk     (ev_clk)
);

// File: tb/wdcm_reset_unit_tb.sv
`timescale 1ns/1ps
module wdcm_reset_unit_tb;
    localparam int  SYS_PERIOD = 10;
    localparam int  REF_PERIOD = 14;
    localparam int  PRE_W_TB   = 4;
    localparam int  TMR_W_TB   = 2;
    localparam int  CM_TO_TB   = 8;
    localparam int  PULSE_TB   = 16;
    localparam real WDOG_NS    = 1500000.0;

    logic       sys_clk = 1'b0, ref_clk = 1'b0;
    logic       sys_rst = 1'b1, ref_rst = 1'b1;
    logic       cop_en = 1'b0, svc_we = 1'b0, clkmon_en = 1'b0, cause_rd = 1'b0;
    logic [1:0] cop_rate = 2'b00;
    logic [7:0] svc_data = 8'h00;
    logic       rst_pulse;
    logic [1:0] cause_code;
    bit         sys_run = 1'b1;
    int         checks = 0, errors = 0;

    wdcm_reset_unit #(.PRE_W(PRE_W_TB), .TMR_W(TMR_W_TB), .CM_TIMEOUT(CM_TO_TB),
                      .SYNC(2), .PULSE_LEN(PULSE_TB)) u_dut (
        .sys_clk(sys_clk), .sys_rst(sys_rst), .ref_clk(ref_clk), .ref_rst(ref_rst),
        .cop_en(cop_en), .cop_rate(cop_rate), .svc_we(svc_we), .svc_data(svc_data),
        .clkmon_en(clkmon_en), .cause_rd(cause_rd),
        .rst_pulse(rst_pulse), .cause_code(cause_code));

    initial forever begin
        #(SYS_PERIOD/2.0);
        if (sys_run) sys_clk = ~sys_clk;
    end
    initial forever #(REF_PERIOD/2.0) ref_clk = ~ref_clk;

    function automatic int exp_cycles(input logic [1:0] r);
        int d;
        d = (r == 2'b00) ? 1 : (r == 2'b01) ? 2 : 4;
        return (1 << PRE_W_TB) * d * (1 << TMR_W_TB);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic svc_write(input logic [7:0] v, output realtime t_edge);
        @(negedge sys_clk);
        svc_we = 1'b1; svc_data = v;
        @(negedge sys_clk);
        svc_we = 1'b0;
        t_edge = $realtime - SYS_PERIOD/2.0;
    endtask

    task automatic anchor(output realtime t0);
        realtime tx;
        svc_write(8'h55, tx);
        svc_write(8'hAA, t0);
    endtask

    task automatic wait_rise(input realtime limit, output realtime tr, output bit seen);
        realtime deadline;
        #0.3;
        deadline = $realtime + limit;
        while ($realtime < deadline && !rst_pulse) #1;
        seen = rst_pulse;
        tr = $realtime;
    endtask

    task automatic measure_width(output int n);
        @(negedge ref_clk);
        n = 0;
        while (rst_pulse && n < 100) begin
            n++;
            @(negedge ref_clk);
        end
    endtask

    task automatic do_read();
        @(negedge ref_clk); cause_rd = 1'b1;
        @(negedge ref_clk); cause_rd = 1'b0;
    endtask

    task automatic cop_trial(input logic [1:0] r, input int njunk, input string tag);
        realtime t0, tw, tr, t_fire;
        bit seen, armed, ok;
        int w;
        logic [7:0] v;
        @(negedge sys_clk); cop_rate = r; cop_en = 1'b1;
        anchor(t0);
        armed = 1'b0;
        for (int i = 0; i < njunk; i++) begin
            case ($urandom % 4)
                0: v = 8'h55;
                1: v = 8'hAA;
                default: v = 8'($urandom);
            endcase
            svc_write(v, tw);
            if (armed && v == 8'hAA) t0 = tw;   // R5 model
            armed = (v == 8'h55);
        end
        t_fire = t0 + exp_cycles(r) * SYS_PERIOD;
        wait_rise(t_fire - $realtime + 20.0 * REF_PERIOD, tr, seen);
        ok = seen && tr > t_fire && tr <= t_fire + 4.0 * REF_PERIOD + 2.0;
        check(ok, tag, "watchdog reset time (ns)", longint'(tr), longint'(t_fire));
        if (seen) begin
            measure_width(w);
            check(w == PULSE_TB, "R7", "pulse width", w, PULSE_TB);
            check(cause_code == 2'b01, "R8", "watchdog cause", cause_code, 2'b01);
            do_read();
            check(cause_code == 2'b00, "R9", "cause after read", cause_code, 2'b00);
        end
        @(negedge sys_clk); cop_en = 1'b0;
        repeat (4) @(negedge sys_clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(WDOG_NS);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        realtime t0, tr, ts, lo, hi;
        bit seen;
        int w;
        void'($urandom(32'd4711));
        repeat (5) @(negedge ref_clk);
        sys_rst = 1'b0; ref_rst = 1'b0;
        repeat (3) @(negedge ref_clk);
        // R1
        check(rst_pulse == 1'b0, "R1", "pulse after reset", rst_pulse, 0);
        check(cause_code == 2'b00, "R1", "cause after reset", cause_code, 0);

        // R2: disabled watchdog, no service
        wait_rise(3000.0, tr, seen);
        check(!seen, "R2", "reset while watchdog disabled", seen, 0);

        // R6: monitor disabled, clock stopped
        @(negedge sys_clk); sys_run = 1'b0;
        wait_rise(40.0 * REF_PERIOD, tr, seen);
        check(!seen, "R6", "reset while monitor disabled", seen, 0);
        sys_run = 1'b1;
        @(negedge ref_clk); clkmon_en = 1'b1;
        repeat (10) @(negedge sys_clk);

        // R3, R4: every rate code, directed
        cop_trial(2'b00, 0, "R4");
        cop_trial(2'b01, 0, "R4");
        cop_trial(2'b10, 0, "R4");
        cop_trial(2'b11, 0, "R4");

        // R5: regular service keeps watchdog quiet
        @(negedge sys_clk); cop_rate = 2'b00; cop_en = 1'b1;
        anchor(t0);
        for (int k = 0; k < 8; k++) begin
            wait_rise(300.0, tr, seen);
            check(!seen, "R5", "reset despite service", seen, 0);
            anchor(t0);
        end
        @(negedge sys_clk); cop_en = 1'b0;
        repeat (4) @(negedge sys_clk);

        // R5: bad orders do not clear
        @(negedge sys_clk); cop_rate = 2'b01; cop_en = 1'b1;
        anchor(t0);
        begin
            realtime tx;
            svc_write(8'hAA, tx); svc_write(8'h55, tx); svc_write(8'h12, tx);
            svc_write(8'hAA, tx); svc_write(8'h55, tx); svc_write(8'h00, tx);
        end
        wait_rise(t0 + exp_cycles(2'b01) * SYS_PERIOD - $realtime + 20.0 * REF_PERIOD, tr, seen);
        lo = t0 + exp_cycles(2'b01) * SYS_PERIOD;
        check(seen && tr > lo && tr <= lo + 4.0 * REF_PERIOD + 2.0, "R5",
              "reset time after bad sequence", longint'(tr), longint'(lo));
        measure_width(w);
        do_read();
        @(negedge sys_clk); cop_en = 1'b0;
        repeat (4) @(negedge sys_clk);

        // R3: random rates with random service traffic
        for (int k = 0; k < 6; k++)
            cop_trial(2'($urandom), 1 + int'($urandom % 5), "R3");

        // R6: clock loss with monitor enabled
        @(negedge sys_clk); sys_run = 1'b0; ts = $realtime;
        wait_rise(40.0 * REF_PERIOD, tr, seen);
        lo = ts + CM_TO_TB * REF_PERIOD;
        hi = ts + (CM_TO_TB + 5) * REF_PERIOD;
        check(seen && tr >= lo && tr <= hi, "R6", "clock-loss reset time", longint'(tr), longint'(lo));
        measure_width(w);
        check(w == PULSE_TB, "R7", "clock-loss pulse width", w, PULSE_TB);
        check(cause_code == 2'b10, "R8", "clock-loss cause", cause_code, 2'b10);
        wait_rise(40.0 * REF_PERIOD, tr, seen);
        check(!seen, "R6", "second reset in one outage", seen, 0);
        sys_run = 1'b1;
        repeat (10) @(negedge sys_clk);

        // R8: watchdog after clock loss keeps the higher cause
        @(negedge sys_clk); cop_rate = 2'b00; cop_en = 1'b1;
        anchor(t0);
        wait_rise(t0 + exp_cycles(2'b00) * SYS_PERIOD - $realtime + 20.0 * REF_PERIOD, tr, seen);
        check(seen, "R3", "watchdog reset after restart", seen, 1);
        @(negedge ref_clk);
        check(cause_code == 2'b10, "R8", "cause kept over watchdog", cause_code, 2'b10);
        measure_width(w);
        @(negedge sys_clk); cop_en = 1'b0;
        do_read();
        check(cause_code == 2'b00, "R9", "cause cleared by read", cause_code, 2'b00);

        finish_run();
    end
endmodule